// File: doc/BRIEF.md
# Multiplexer-Tree Word Serializer

The block turns a parallel word into a serial bit stream. Instead of a shift register, it uses a tree of 2:1 multiplexer levels. Each level halves the number of lanes and updates twice as often as the level in front of it. With the default 16-bit word there are four levels (16 to 8 to 4 to 2 to 1), and they update every 8, 4, 2 and 1 bit-clock cycles. The word register in front of the tree updates every 16 cycles. The whole block runs on the single bit clock. The slower levels are paced by enable strobes decoded from one word-phase counter, and every level retimes its lanes in its own register bank.

The block tells the upstream source when it samples a word by raising a one-cycle take strobe, once per word period. The source keeps `word_i` valid in that cycle. The serial bit leaves least significant bit first. A frame flag marks slot 0 of every word, and a valid flag marks the stream as live once the first captured word reaches the output. The delay from capture to slot 0 is fixed at one register per level, so words follow each other with no gaps.

Top module: `tree_serializer`

## Requirements
- R1: `word_take_o` is high in the first cycle after reset is released and then once every WORD_W cycles. It is low in all other cycles.
- R2: `word_i` is sampled only at the rising edge that ends a cycle in which `word_take_o` is high. Values driven on `word_i` in any other cycle have no effect on `ser_o`.
- R3: Bits leave least significant first: bit i of a captured word appears on `ser_o` in serial slot i, where slot 0 is the cycle in which `frame_o` is high.
- R4: `frame_o` is high for exactly one cycle per word. That cycle comes LEVELS+1 cycles after the cycle in which `word_take_o` was high, where LEVELS = log2(WORD_W). This is 5 cycles for a 16-bit word.
- R5: Successive words are serialized back to back with no idle slots. The frame repeats every WORD_W cycles with the same latency for every word, and every accepted word is delivered.
- R6: A synchronous active-high reset clears the word register, every level register, the phase counter and the flags. During reset and in the cycle after it, `ser_o`, `frame_o` and `valid_o` are 0 and `word_take_o` is 1, including when reset arrives in the middle of a word.
- R7: `valid_o` and `ser_o` stay 0 until the first frame. `valid_o` rises together with that frame and then stays high until the next reset.
- R8: The tree has log2(WORD_W) levels, and each halves the lane count. A level register changes only on its own enable, which fires once every WORD_W>>k cycles for level k. Lane j of a level with N lanes takes lane j of the level before it and then lane j+N.
- R9: A PRBS7 stream (polynomial x^7+x^6+1), packed LSB first into consecutive words, comes out of `ser_o` bit for bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial slot per cycle |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | WORD_W | Parallel word, sampled when `word_take_o` is high |
| word_take_o | output | 1 | One-cycle strobe marking the cycle in which `word_i` is sampled |
| ser_o | output | 1 | Serial data, LSB first |
| frame_o | output | 1 | High with serial slot 0 of each word |
| valid_o | output | 1 | High once the first word has reached the output |

## Verification
On every cycle, the assertions check the phase counter wrap, the single-cycle take pulse, and that each level register holds still outside its enable. They also check that every frame sits LEVELS+1 cycles behind a take strobe and that `valid_o` rises only with a frame and never falls. The bit order, the end-to-end integrity of PRBS7 and random words, the blindness of the tree to `word_i` outside the take cycle, and the restart after a mid-word reset can be shown only by the bench's scenarios. The bench rebuilds words from the frame-aligned stream and compares them with what it sent.

// File: rtl/ser_tree_pkg.sv
package ser_tree_pkg;

   // Word width accepted by the tree: a power of two, at least four lanes.
   function automatic bit word_width_ok(input int n);
      return (n >= 4) && ((n & (n - 1)) == 0);
   endfunction

   // Number of 2:1 levels needed to fold n lanes down to one.
   function automatic int tree_depth(input int n);
      return $clog2(n);
   endfunction

endpackage

// File: rtl/ser_phase_ctr.sv
module ser_phase_ctr #(
   parameter int WORD_W = 16,
   parameter int LEVELS = 4
) (
   input  logic              clk,
   input  logic              rst,
   output logic [LEVELS:0]   lvl_en_o,
   output logic [LEVELS:1]   lvl_sel_o,
   output logic              slot0_o
);

   localparam logic [LEVELS-1:0] SLOT0_PHASE = LEVELS'(LEVELS);

   logic [LEVELS-1:0] phase_q;

   // Word-phase counter; wraps naturally because WORD_W is a power of two.
   always_ff @(posedge clk) begin
      if (rst) phase_q <= '0;
      else     phase_q <= phase_q + 1'b1;
   end

   // Level k runs k cycles behind the capture and updates every WORD_W>>k
   // cycles; its half select is the next phase bit above the enable field.
   for (genvar k = 0; k <= LEVELS; k++) begin : g_lvl
      if (k == 0) begin : g_capture
         assign lvl_en_o[0] = (phase_q == '0);
      end else if (k == LEVELS) begin : g_last
         localparam logic OFS0 = 1'(k);
         assign lvl_en_o[k]  = 1'b1;
         assign lvl_sel_o[k] = phase_q[0] ^ OFS0;
      end else begin : g_mid
         localparam int        DW  = LEVELS - k + 1;
         localparam logic [DW-1:0] OFS = DW'(k);
         logic [DW-1:0] rel;
         assign rel          = phase_q[DW-1:0] - OFS;
         assign lvl_en_o[k]  = (rel[DW-2:0] == '0);
         assign lvl_sel_o[k] = rel[DW-1];
      end
   end

   assign slot0_o = (phase_q == SLOT0_PHASE);

   // R1
   phase_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (phase_q == '1) |=> (phase_q == '0));

   // R1
   take_single_chk: assert property (@(posedge clk) disable iff (rst)
      lvl_en_o[0] |=> !lvl_en_o[0]);

endmodule

// File: rtl/ser_mux_level.sv
module ser_mux_level #(
   parameter int LANES = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               en,
   input  logic               sel,
   input  logic [2*LANES-1:0] lanes_i,
   output logic [LANES-1:0]   lanes_o
);

   logic [LANES-1:0] pick;

   // Lane j folds lane j (first half-period) and lane j+LANES (second).
   for (genvar j = 0; j < LANES; j++) begin : g_lane
      assign pick[j] = sel ? lanes_i[j + LANES] : lanes_i[j];
   end

   always_ff @(posedge clk) begin
      if (rst)     lanes_o <= '0;
      else if (en) lanes_o <= pick;
   end

   // R8
   hold_off_en_chk: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(lanes_o));

endmodule

// File: rtl/tree_serializer.sv
module tree_serializer
   import ser_tree_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [WORD_W-1:0] word_i,
   output logic              word_take_o,
   output logic              ser_o,
   output logic              frame_o,
   output logic              valid_o
);

   localparam int LEVELS = tree_depth(WORD_W);

   if (!word_width_ok(WORD_W)) begin : g_bad_width
      $error("tree_serializer: WORD_W must be a power of two of at least 4");
   end

   logic [LEVELS:0] lvl_en;
   logic [LEVELS:1] lvl_sel;
   logic            slot0;
   logic            frame_q;
   logic            valid_q;

   ser_phase_ctr #(
      .WORD_W (WORD_W),
      .LEVELS (LEVELS)
   ) u_phase (
      .clk       (clk),
      .rst       (rst),
      .lvl_en_o  (lvl_en),
      .lvl_sel_o (lvl_sel),
      .slot0_o   (slot0)
   );

   // Level 0 is the word register; levels 1..LEVELS are 2:1 fold stages.
   for (genvar k = 0; k <= LEVELS; k++) begin : lvl
      localparam int N = WORD_W >> k;
      logic [N-1:0] lanes;
      if (k == 0) begin : g_word
         always_ff @(posedge clk) begin
            if (rst)            lanes <= '0;
            else if (lvl_en[0]) lanes <= word_i;
         end
      end else begin : g_fold
         ser_mux_level #(
            .LANES (N)
         ) u_fold (
            .clk     (clk),
            .rst     (rst),
            .en      (lvl_en[k]),
            .sel     (lvl_sel[k]),
            .lanes_i (lvl[k-1].lanes),
            .lanes_o (lanes)
         );
      end
   end

   // Flags register on the same edge as the last fold stage.
   always_ff @(posedge clk) begin
      if (rst) begin
         frame_q <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         frame_q <= slot0;
         if (slot0) valid_q <= 1'b1;
      end
   end

   assign word_take_o = lvl_en[0];
   assign frame_o     = frame_q;
   assign valid_o     = valid_q;
   assign ser_o       = lvl[LEVELS].lanes[0] & valid_q;

   // R4
   frame_after_take_chk: assert property (@(posedge clk) disable iff (rst)
      frame_o |-> $past(word_take_o, LEVELS + 1));

   // R7
   valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      valid_o |=> valid_o);

   // R7
   valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(valid_o) |-> frame_o);

   // R5
   frame_single_chk: assert property (@(posedge clk) disable iff (rst)
      frame_o |=> !frame_o);

endmodule

// File: tb/tree_serializer_tb_top.sv
`timescale 1ns/1ps
module tree_serializer_tb_top;

   localparam int W  = 16;
   localparam int L  = 4;
   localparam int LAT = L + 1;
   localparam int N_DIRECTED = 6;
   localparam int N_PRBS     = 120;
   localparam int MAXW       = 512;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] word_i = '0;
   logic         word_take_o, ser_o, frame_o, valid_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [W-1:0] exp_q [0:MAXW-1];
   int           kind_q [0:MAXW-1];
   logic [6:0]   prbs_s;

   always #2.5 clk = ~clk;

   tree_serializer #(.WORD_W(W)) dut_i (
      .clk         (clk),
      .rst         (rst),
      .word_i      (word_i),
      .word_take_o (word_take_o),
      .ser_o       (ser_o),
      .frame_o     (frame_o),
      .valid_o     (valid_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input int kind);
      case (kind)
         0:       return "R3 R8";
         1:       return "R9";
         default: return "R5 R2";
      endcase
   endfunction

   // PRBS7, x^7 + x^6 + 1, packed LSB first.
   function automatic logic [W-1:0] prbs_word();
      logic [W-1:0] w;
      logic nb;
      for (int i = 0; i < W; i++) begin
         nb     = prbs_s[6] ^ prbs_s[5];
         prbs_s = {prbs_s[5:0], nb};
         w[i]   = nb;
      end
      return w;
   endfunction

   function automatic logic [W-1:0] directed_word(input int n);
      case (n)
         0:       return '0;
         1:       return '1;
         2:       return W'(1);
         3:       return W'(1) << (W - 1);
         4:       return {(W/2){2'b10}};
         default: return {(W/2){2'b01}};
      endcase
   endfunction

   // Starts at the negedge where reset is released.
   task automatic run_session(input int nwords);
      int sent = 0;
      int rd = 0;
      int pos = 0;
      logic [W-1:0] asmw = '0;
      int total = nwords * W + LAT;
      bit exp_frame;
      prbs_s = 7'h7F;
      rst = 1'b0;
      for (int idx = 0; idx < total; idx++) begin
         exp_frame = (idx >= LAT) && (((idx - LAT) % W) == 0);
         chk(word_take_o == ((idx % W) == 0), "R1", "word_take_o", word_take_o, (idx % W) == 0);
         chk(frame_o == exp_frame, "R4", "frame_o", frame_o, exp_frame);
         chk(valid_o == (idx >= LAT), "R7", "valid_o", valid_o, idx >= LAT);
         if (!valid_o) chk(ser_o == 1'b0, "R7", "ser_o before first frame", ser_o, 0);
         if (frame_o) pos = 0;
         if (valid_o && pos < W && rd < nwords) begin
            asmw[pos] = ser_o;
            pos++;
            if (pos == W) begin
               chk(asmw == exp_q[rd], tag_of(kind_q[rd]), "rebuilt word", asmw, exp_q[rd]);
               rd++;
            end
         end
         if (word_take_o && sent < nwords) begin
            if (sent < N_DIRECTED) begin
               exp_q[sent] = directed_word(sent); kind_q[sent] = 0;
            end else if (sent < N_DIRECTED + N_PRBS) begin
               exp_q[sent] = prbs_word(); kind_q[sent] = 1;
            end else begin
               exp_q[sent] = W'($urandom); kind_q[sent] = 2;
            end
            word_i = exp_q[sent];
            sent++;
         end else begin
            word_i = W'($urandom);  // R2: must be ignored
         end
         @(negedge clk);
      end
      chk(rd == nwords, "R5", "words delivered", rd, nwords);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R6: reset state
      chk(ser_o == 1'b0,   "R6", "ser_o in reset",   ser_o, 0);
      chk(frame_o == 1'b0, "R6", "frame_o in reset", frame_o, 0);
      chk(valid_o == 1'b0, "R6", "valid_o in reset", valid_o, 0);
      chk(word_take_o == 1'b1, "R6", "take in reset", word_take_o, 1);
      run_session(N_DIRECTED + N_PRBS + 60);

      // Mid-word reset, then restart.
      for (int i = 0; i < 7; i++) begin
         word_i = W'($urandom);
         @(negedge clk);
      end
      rst = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk(ser_o == 1'b0,   "R6", "ser_o after mid reset",   ser_o, 0);
      chk(frame_o == 1'b0, "R6", "frame_o after mid reset", frame_o, 0);
      chk(valid_o == 1'b0, "R6", "valid_o after mid reset", valid_o, 0);
      chk(word_take_o == 1'b1, "R6", "take after mid reset", word_take_o, 1);
      run_session(N_DIRECTED + 20);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule